// File: doc/BRIEF.md
# Frame-Sync Word Deserializer

This block turns a serial bit stream back into parallel words. Every cycle of the bit clock it takes one data bit and one frame-sync bit, both sampled on the rising edge. Bits arrive most significant first. Word alignment comes only from the frame-sync line, which a link normally pulses once per word, so at one eighth of the bit rate. The block does no clock recovery, performs no domain crossing and has no handshake.

The parameter `SYNC_AT_END` fixes what a sync pulse means:

- **Leading mode** (`SYNC_AT_END = 0`): a pulse marks the first bit of a word. A bit counter then collects the rest of the word.
- **Trailing mode** (`SYNC_AT_END = 1`): a pulse marks the last bit of a word. It acts as a latch enable that moves the most recent `WORD_W` bits to the output.

The controller has three states:

| State | Leading mode | Trailing mode |
|-------|--------------|---------------|
| HUNT (after reset) | Sync goes to FILL and loads a count of 1. | Sync captures a word and goes to FILL. |
| FILL | A bit with no sync increments the count. The `WORD_W`-th bit captures the word and goes to HOLD. A sync here drops the partial word, sets the sticky error flag and restarts the count at 1. | Every sync captures a word. |
| HOLD | Bits with no sync are ignored. A sync returns to FILL with a count of 1. | Not used. |

Top module: `fsd_deser`

## Requirements
- R1: In leading mode, the bit sampled together with a high `sync_in` becomes bit 7 (MSB) of the new word. The next seven bits fill bits 6 down to 0 in arrival order.
- R2: In leading mode, the eighth bit of a word is sampled at some rising edge. At that edge `word_out` takes the complete word, and `word_vld` is high for exactly the one following cycle. With sync every eighth bit, a new word is presented every eight cycles with no gap.
- R3: In trailing mode, at each edge where `sync_in` is high, `word_out` becomes the last eight sampled bits. The bit sampled at that edge is bit 0 and the bit seven edges earlier is bit 7. Bits sampled before reset release count as 0. `word_vld` is high for the following cycle.
- R4: During reset, `word_out`, `word_vld` and `frame_err` are 0. After reset, no `word_vld` pulse occurs until a high `sync_in` has been sampled.
- R5: `word_out` keeps its value in every cycle that does not follow a capture.
- R6: In leading mode, a sync that arrives after 1 to 7 bits of a word have been collected has two effects. First, the partial word is dropped and never presented. Second, `frame_err` rises and stays 1 until reset. The sync bit starts a new word.
- R7: In leading mode, bits that arrive after a complete word and before the next sync change nothing at the outputs.
- R8: In trailing mode, `frame_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit, MSB of each word first |
| sync_in | input | 1 | Frame sync: first bit (leading mode) or last bit (trailing mode) of a word |
| word_out | output | WORD_W | Last captured parallel word |
| word_vld | output | 1 | One-cycle strobe in the cycle after a capture |
| frame_err | output | 1 | Sticky flag: sync arrived mid-word (leading mode only) |

## Verification
A wrong bit count in FILL shows up at the ports within one word time. The `word_vld` pulse lands early or late, or the word presented is shifted by the count error. A state stuck in HUNT or HOLD shows up as missing strobes after the next sync. A wrong capture-enable shows up as `word_out` changing in a cycle with no strobe before it. An error flag that clears or never sets differs from the model on the first clock after an early sync. The model is compared against both framing variants on every clock, so each of these faults is caught at the first cycle where it diverges.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } fsd_state_e;
endpackage

// File: rtl/fsd_shifter.sv
module fsd_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [WORD_W-1:0] next_word
);
    // Only WORD_W-1 history bits are stored; the current bit completes the word.
    localparam int HIST_W = WORD_W - 1;

    logic [HIST_W-1:0] hist_q;

    assign next_word = {hist_q, ser_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= next_word[HIST_W-1:0];
    end
endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
    import fsd_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter bit SYNC_AT_END = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic cap,
    output logic frame_err
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    fsd_state_e        st_q, st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              err_q, err_set;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            if (err_set) err_q <= 1'b1;
        end
    end

    // Next state and output process
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        cap     = 1'b0;
        err_set = 1'b0;
        if (SYNC_AT_END) begin
            unique case (st_q)
                ST_HUNT: if (sync_in) begin
                    cap  = 1'b1;
                    st_n = ST_FILL;
                end
                ST_FILL: if (sync_in) cap = 1'b1;
                default: st_n = ST_HUNT;
            endcase
        end else begin
            unique case (st_q)
                ST_HUNT: if (sync_in) begin
                    st_n  = ST_FILL;
                    cnt_n = ONE_CNT;
                end
                ST_FILL: begin
                    if (sync_in) begin
                        err_set = 1'b1;
                        cnt_n   = ONE_CNT;
                    end else if (cnt_q == LAST_IDX) begin
                        cap   = 1'b1;
                        cnt_n = FULL_CNT;
                        st_n  = ST_HOLD;
                    end else begin
                        cnt_n = cnt_q + ONE_CNT;
                    end
                end
                ST_HOLD: if (sync_in) begin
                    st_n  = ST_FILL;
                    cnt_n = ONE_CNT;
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    assign frame_err = err_q;

    generate
        if (SYNC_AT_END) begin : g_end_chk
            a_r8_no_err_trailing: assert property (@(posedge clk) disable iff (!rst_n)
                !frame_err);
        end else begin : g_start_chk
            a_r6_early_sync_flags: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_FILL && sync_in) |=> frame_err);
            a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                frame_err |=> frame_err);
            a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
                cap |=> !cap);
        end
    endgenerate
endmodule

// File: rtl/fsd_outreg.sv
module fsd_outreg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= cap;
            if (cap) word_out <= din;
        end
    end
endmodule

// File: rtl/fsd_deser.sv
module fsd_deser #(
    parameter int WORD_W      = 8,
    parameter bit SYNC_AT_END = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sync_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              frame_err
);
    logic [WORD_W-1:0] next_word;
    logic              cap;

    fsd_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .next_word (next_word)
    );

    fsd_ctrl #(.WORD_W(WORD_W), .SYNC_AT_END(SYNC_AT_END)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .cap       (cap),
        .frame_err (frame_err)
    );

    fsd_outreg #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .din      (next_word),
        .word_out (word_out),
        .word_vld (word_vld)
    );

    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(word_out));
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> word_vld);
    a_r4_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!word_vld && !frame_err));
endmodule

// File: tb/tb_fsd_deser.sv
`timescale 1ns/1ps
module tb_fsd_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser = 1'b0;
    logic       sync = 1'b0;
    logic [7:0] s_wo, e_wo;
    logic       s_vl, e_vl, s_er, e_er;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fsd_deser #(.WORD_W(8), .SYNC_AT_END(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser), .sync_in(sync),
        .word_out(s_wo), .word_vld(s_vl), .frame_err(s_er));

    fsd_deser #(.WORD_W(8), .SYNC_AT_END(1'b1)) dut_end (
        .clk(clk), .rst_n(rst_n), .ser_in(ser), .sync_in(sync),
        .word_out(e_wo), .word_vld(e_vl), .frame_err(e_er));

    // Behavioural reference model
    int         m_cnt = 0;          // 0: no sync yet, 1..7 collecting, 8 complete
    bit         m_bits[$];
    logic [7:0] m_sword = '0;
    bit         m_svld = 0, m_serr = 0, m_sseen = 0;
    bit         m_ebits[$];
    logic [7:0] m_eword = '0;
    bit         m_evld = 0, m_eseen = 0;

    function automatic logic [7:0] pack8(bit q[$]);
        logic [7:0] w = '0;
        foreach (q[i]) w = {w[6:0], q[i]};
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_bits = {}; m_sword = '0; m_svld = 0; m_serr = 0; m_sseen = 0;
            m_ebits = {0, 0, 0, 0, 0, 0, 0, 0};
            m_eword = '0; m_evld = 0; m_eseen = 0;
        end else begin
            m_svld = 0;
            if (sync) begin
                if (m_cnt >= 1 && m_cnt <= 7) m_serr = 1;
                m_bits = {ser};
                m_cnt = 1;
                m_sseen = 1;
            end else if (m_cnt >= 1 && m_cnt < 8) begin
                m_bits.push_back(ser);
                m_cnt++;
                if (m_cnt == 8) begin
                    m_sword = pack8(m_bits);
                    m_svld = 1;
                end
            end
            m_ebits.push_back(ser);
            if (m_ebits.size() > 8) void'(m_ebits.pop_front());
            m_evld = sync;
            if (sync) begin
                m_eword = pack8(m_ebits);
                m_eseen = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            string t;
            vectors++;
            if (!rst_n) t = "R4";
            else if (!m_sseen) t = "R4";
            else if (m_svld) t = "R2";
            else if (m_cnt == 8) t = "R7";
            else t = "R5";
            if (s_vl !== m_svld) begin
                fails++;
                $display("FAIL %s lead vld act=%0b exp=%0b t=%0t", t, s_vl, m_svld, $time);
            end
            if (s_wo !== m_sword) begin
                fails++;
                $display("FAIL %s lead word act=%02h exp=%02h t=%0t",
                         (m_svld ? "R1" : t), s_wo, m_sword, $time);
            end
            if (s_er !== m_serr) begin
                fails++;
                $display("FAIL R6 lead err act=%0b exp=%0b t=%0t", s_er, m_serr, $time);
            end
            vectors++;
            if (!rst_n || !m_eseen) t = "R4";
            else if (m_evld) t = "R3";
            else t = "R5";
            if (e_vl !== m_evld) begin
                fails++;
                $display("FAIL %s trail vld act=%0b exp=%0b t=%0t", t, e_vl, m_evld, $time);
            end
            if (e_wo !== m_eword) begin
                fails++;
                $display("FAIL %s trail word act=%02h exp=%02h t=%0t", t, e_wo, m_eword, $time);
            end
            if (e_er !== 1'b0) begin
                fails++;
                $display("FAIL R8 trail err act=%0b exp=0 t=%0t", e_er, $time);
            end
        end
    end

    task automatic drive(input bit b, input bit f);
        @(negedge clk);
        ser  = b;
        sync = f;
    endtask

    task automatic send_word(input logic [7:0] w, input int sync_pos);
        for (int i = 0; i < 8; i++) drive(w[7-i], i == sync_pos);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R4: bits with no sync produce nothing
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b0);
        // R1/R2: back-to-back words framed on their first bit
        send_word(8'hA5, 0); send_word(8'h3C, 0);
        send_word(8'hFF, 0); send_word(8'h01, 0);
        // R7/R5: idle bits after a complete word
        for (int i = 0; i < 6; i++) drive(i[0], 1'b0);
        // R6: early sync after four bits
        for (int i = 0; i < 4; i++) drive(1'b1, i == 0);
        send_word(8'h96, 0);
        // R3: words framed on their last bit
        send_word(8'hC3, 7); send_word(8'h5A, 7); send_word(8'h80, 7);
        // Mixed random traffic
        for (int i = 0; i < 300; i++) drive(1'($urandom), ($urandom % 6) == 0);
        // R4/R8: second reset and regular framing
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send_word(8'h7E, 0); send_word(8'hE7, 0);
        drive(1'b0, 1'b0); drive(1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule